// File: doc/BRIEF.md
# Link Character Codec with Credit Flow Control

This block sits between a packet source/sink and a one-bit-per-clock serial line. On the transmit side it turns a stream of bytes and end-of-packet markers into framed characters, each carrying a parity bit and a data/control flag. When it has nothing it may send, it fills the line with idle characters. Data is released only against credit. The far end grants credit by sending flow-control tokens, and each token grants eight characters.

On the receive side it frames the incoming bit stream back into characters and checks parity. Flow-control tokens are handed to the local credit counter and never reach the data output; only bytes and end markers are forwarded. The consumer pulses a slot-free input each time it drains one entry of its receive buffer. Every eighth pulse makes the transmitter send one flow-control token to the far end. The line code and the link start-up sequencing are outside this block.

Top module: `link_char_codec`

## Requirements
- R1: After reset the transmit line starts at once with an idle pair (escape then flow token), whose bits in line order are 0,1,1,1,0,1,0,0.
- R2: Every character is sent parity bit first, then the flag, then the payload least significant bit first. A data character has flag 0 and 8 payload bits. A control character has flag 1 and a 2-bit code: flow token 0, normal end 1, error end 2, escape 3. tx_kind/rx_kind use 0 for data, 1 for normal end and 2 for error end; 3 is never driven.
- R3: Parity is odd over the payload bits of the previous character, the parity bit and the flag of the current character; before the first character the previous payload counts as all zero.
- R4: When no credit remains or no item is offered, the transmitter sends idle pairs continuously.
- R5: Each flow token received grants 8 credits, each data or end character sent uses one, and no such character is sent while the credit is zero.
- R6: A pending outgoing flow token is sent before any further data character.
- R7: Received data characters appear on rx_valid with rx_kind 0 and the byte; received end characters appear with rx_kind 1 or 2, in arrival order.
- R8: A received flow token is never forwarded; an escape followed by a flow token is an idle pair and grants no credit.
- R9: A received character that fails the parity rule raises rx_parity_err for one cycle and is not forwarded.
- R10: Each eighth rx_slot_free pulse queues one flow token to send; fewer pulses queue none.
- R11: tx_ready pulses once per item taken, only while tx_valid is high, and each taken item is sent exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | input | 1 | An item is offered for sending |
| tx_kind | input | 2 | Item kind: 0 data, 1 normal end, 2 error end |
| tx_byte | input | 8 | Data byte of the offered item |
| tx_ready | output | 1 | Offered item is taken at this clock edge |
| tx_bit | output | 1 | Serial transmit bit, one per clock |
| rx_bit | input | 1 | Serial receive bit |
| rx_bit_en | input | 1 | rx_bit carries a valid bit this cycle |
| rx_slot_free | input | 1 | One receive buffer slot was freed |
| rx_valid | output | 1 | A received item is presented for one cycle |
| rx_kind | output | 2 | Received item kind, coded as tx_kind |
| rx_byte | output | 8 | Received data byte |
| rx_parity_err | output | 1 | One-cycle pulse on a parity failure |

## Verification
The assertions take for granted that the far end never grants more credit than the counter can hold, so at most seven tokens are outstanding. They also assume the consumer never frees slots faster than queued tokens drain, and that tx_kind is never 3. The stimulus grants at most five tokens at a time and only after the earlier credit is spent. It frees slots in bursts of eight at most, and it draws every offered item from a fixed arithmetic sequence that uses only the three legal kinds. Each input bit is presented for exactly one cycle with rx_bit_en high.

// File: rtl/link_codec_pkg.sv
// Shared encodings for the link character codec.
// Assumes the control code field is two bits wide and sent LSB first.
package link_codec_pkg;
    typedef enum logic [1:0] {
        CC_FCT = 2'd0,
        CC_EOP = 2'd1,
        CC_EEP = 2'd2,
        CC_ESC = 2'd3
    } ctrl_code_e;

    localparam logic [1:0] KIND_DATA = 2'd0;
    localparam logic [1:0] KIND_EOP  = 2'd1;
    localparam logic [1:0] KIND_EEP  = 2'd2;

    localparam int CTRL_LEN = 4;
endpackage

// File: rtl/lc_credit.sv
// Transmit credit counter: adds GRANT per received flow token and removes
// one per data or end character sent.
// Assumes the far end never grants beyond CREDIT_MAX.
module lc_credit #(
    parameter int GRANT      = 8,
    parameter int CREDIT_MAX = 56
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    input  logic take,
    output logic has_credit
);
    localparam int CW = $clog2(CREDIT_MAX + 1);

    logic [CW-1:0] credit;

    // Credit update on grant and use.
    always_ff @(posedge clk) begin
        if (!rst_n)
            credit <= '0;
        else
            credit <= credit + (grant ? CW'(GRANT) : CW'(0)) - (take ? CW'(1) : CW'(0));
    end

    assign has_credit = (credit != '0);

    AST_CREDIT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (int'(credit) + GRANT <= CREDIT_MAX)); // R5
    AST_TAKE_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (credit != '0)); // R5
endmodule

// File: rtl/lc_fct_req.sv
// Counts freed receive slots and queues one outgoing flow token per GRANT
// slots. Assumes queued tokens drain before PEND_MAX is exceeded.
module lc_fct_req #(
    parameter int GRANT    = 8,
    parameter int PEND_MAX = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_free,
    input  logic sent,
    output logic pending
);
    localparam int SCW = (GRANT > 1) ? $clog2(GRANT) : 1;
    localparam int PW  = $clog2(PEND_MAX + 1);

    logic [SCW-1:0] slots;
    logic [PW-1:0]  pend;
    logic           wrap;

    assign wrap = slot_free && (slots == SCW'(GRANT - 1));

    // Freed-slot counter wrapping at GRANT.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slots <= '0;
        else if (slot_free)
            slots <= wrap ? '0 : slots + SCW'(1);
    end

    // Outstanding token count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= '0;
        else
            pend <= pend + (wrap ? PW'(1) : PW'(0)) - (sent ? PW'(1) : PW'(0));
    end

    assign pending = (pend != '0);

    AST_FCT_PEND_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !sent) |-> (int'(pend) < PEND_MAX)); // R10
    AST_SENT_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        sent |-> (pend != '0)); // R10
endmodule

// File: rtl/lc_tx.sv
// Transmit character builder and serializer. Picks the next character at the
// last bit of the current one: second half of an idle pair, then a queued
// flow token, then a credited item, else an escape opening an idle pair.
// Assumes tx_kind is never 3.
module lc_tx
    import link_codec_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_valid,
    input  logic [1:0]           tx_kind,
    input  logic [DATA_BITS-1:0] tx_byte,
    input  logic                 has_credit,
    input  logic                 fct_pending,
    output logic                 tx_ready,
    output logic                 fct_sent,
    output logic                 take,
    output logic                 tx_bit
);
    localparam int SW = DATA_BITS + 2;
    localparam int CW = $clog2(SW + 1);

    logic [SW-1:0] sr;
    logic [CW-1:0] cnt;
    logic          null_half;
    logic          prev_par;

    logic          load;
    logic          is_ctrl;
    ctrl_code_e    code;
    logic          next_null;
    logic          par_bit;
    logic          pay_par;
    logic [SW-1:0] nxt_word;
    logic [CW-1:0] nxt_len;

    assign load = (cnt == CW'(1));

    // Choice of the next character.
    always_comb begin
        is_ctrl   = 1'b1;
        code      = CC_ESC;
        next_null = 1'b0;
        tx_ready  = 1'b0;
        fct_sent  = 1'b0;
        take      = 1'b0;
        if (null_half) begin
            code = CC_FCT;
        end else if (fct_pending) begin
            code     = CC_FCT;
            fct_sent = load;
        end else if (tx_valid && has_credit) begin
            take     = load;
            tx_ready = load;
            if (tx_kind == KIND_DATA)
                is_ctrl = 1'b0;
            else if (tx_kind == KIND_EOP)
                code = CC_EOP;
            else
                code = CC_EEP;
        end else begin
            code      = CC_ESC;
            next_null = 1'b1;
        end
    end

    // Parity and framing of the chosen character.
    always_comb begin
        pay_par  = is_ctrl ? ^code : ^tx_byte;
        par_bit  = ~(prev_par ^ is_ctrl);
        nxt_word = is_ctrl ? SW'({code, 1'b1, par_bit}) : {tx_byte, 1'b0, par_bit};
        nxt_len  = is_ctrl ? CW'(CTRL_LEN) : CW'(SW);
    end

    // Shift register, bit count and idle-pair state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr        <= SW'({CC_ESC, 1'b1, 1'b0});
            cnt       <= CW'(CTRL_LEN);
            null_half <= 1'b1;
            prev_par  <= 1'b0;
        end else if (load) begin
            sr        <= nxt_word;
            cnt       <= nxt_len;
            null_half <= next_null;
            prev_par  <= pay_par;
        end else begin
            sr  <= sr >> 1;
            cnt <= cnt - CW'(1);
        end
    end

    assign tx_bit = sr[0];

    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (tx_valid && has_credit)); // R11
    AST_ONE_TAKE_PER_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> !tx_ready); // R11
    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_kind != 2'd3)); // R2
endmodule

// File: rtl/lc_rx.sv
// Receive character parser. Frames parity, flag and payload, checks odd
// parity, turns flow tokens into credit pulses, drops idle pairs and
// forwards data and end characters. Assumes framing starts at reset.
module lc_rx
    import link_codec_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_bit,
    input  logic                 rx_bit_en,
    output logic                 rx_valid,
    output logic [1:0]           rx_kind,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_parity_err,
    output logic                 fct_rcvd
);
    localparam int SW = DATA_BITS + 2;
    localparam int CW = $clog2(SW + 1);

    logic [CW-1:0]        pos;
    logic                 pbit;
    logic                 ctrl_r;
    logic                 bad_r;
    logic                 prev_par;
    logic                 run_par;
    logic                 esc_seen;
    logic [DATA_BITS-1:0] acc;

    logic                 last;
    ctrl_code_e           code;

    assign last = (pos == (ctrl_r ? CW'(CTRL_LEN - 1) : CW'(SW - 1)));
    assign code = ctrl_code_e'({rx_bit, acc[DATA_BITS-1]});

    // Bit framing, parity check and character dispatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos           <= '0;
            pbit          <= 1'b0;
            ctrl_r        <= 1'b0;
            bad_r         <= 1'b0;
            prev_par      <= 1'b0;
            run_par       <= 1'b0;
            esc_seen      <= 1'b0;
            acc           <= '0;
            rx_valid      <= 1'b0;
            rx_kind       <= KIND_DATA;
            rx_byte       <= '0;
            rx_parity_err <= 1'b0;
            fct_rcvd      <= 1'b0;
        end else begin
            rx_valid      <= 1'b0;
            rx_parity_err <= 1'b0;
            fct_rcvd      <= 1'b0;
            if (rx_bit_en) begin
                if (pos == '0) begin
                    pbit <= rx_bit;
                    pos  <= CW'(1);
                end else if (pos == CW'(1)) begin
                    ctrl_r        <= rx_bit;
                    bad_r         <= ~(pbit ^ prev_par ^ rx_bit);
                    rx_parity_err <= ~(pbit ^ prev_par ^ rx_bit);
                    run_par       <= 1'b0;
                    pos           <= CW'(2);
                end else begin
                    acc     <= {rx_bit, acc[DATA_BITS-1:1]};
                    run_par <= run_par ^ rx_bit;
                    if (!last) begin
                        pos <= pos + CW'(1);
                    end else begin
                        pos      <= '0;
                        prev_par <= run_par ^ rx_bit;
                        esc_seen <= 1'b0;
                        if (!bad_r) begin
                            if (!ctrl_r) begin
                                rx_valid <= 1'b1;
                                rx_kind  <= KIND_DATA;
                                rx_byte  <= {rx_bit, acc[DATA_BITS-1:1]};
                            end else begin
                                case (code)
                                    CC_FCT: fct_rcvd <= !esc_seen;
                                    CC_ESC: esc_seen <= 1'b1;
                                    CC_EOP: begin
                                        rx_valid <= 1'b1;
                                        rx_kind  <= KIND_EOP;
                                        rx_byte  <= '0;
                                    end
                                    default: begin
                                        rx_valid <= 1'b1;
                                        rx_kind  <= KIND_EEP;
                                        rx_byte  <= '0;
                                    end
                                endcase
                            end
                        end
                    end
                end
            end
        end
    end

    AST_RX_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid, fct_rcvd, rx_parity_err})); // R8
    AST_RX_OUT_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid || fct_rcvd) |-> $past(rx_bit_en)); // R7
endmodule

// File: rtl/link_char_codec.sv
// Top of the link character codec: transmit builder, receive parser,
// credit counter and outgoing flow-token queue.
// Assumes one line bit per clock on transmit and framing from reset.
module link_char_codec
    import link_codec_pkg::*;
#(
    parameter int DATA_BITS      = 8,
    parameter int CREDIT_PER_FCT = 8,
    parameter int CREDIT_MAX     = 56,
    parameter int FCT_PEND_MAX   = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_valid,
    input  logic [1:0]           tx_kind,
    input  logic [DATA_BITS-1:0] tx_byte,
    output logic                 tx_ready,
    output logic                 tx_bit,
    input  logic                 rx_bit,
    input  logic                 rx_bit_en,
    input  logic                 rx_slot_free,
    output logic                 rx_valid,
    output logic [1:0]           rx_kind,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_parity_err
);
    logic has_credit;
    logic fct_pending;
    logic fct_sent;
    logic take;
    logic fct_rcvd;

    lc_tx #(.DATA_BITS(DATA_BITS)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_kind(tx_kind), .tx_byte(tx_byte),
        .has_credit(has_credit), .fct_pending(fct_pending),
        .tx_ready(tx_ready), .fct_sent(fct_sent), .take(take),
        .tx_bit(tx_bit)
    );

    lc_rx #(.DATA_BITS(DATA_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .rx_bit(rx_bit), .rx_bit_en(rx_bit_en),
        .rx_valid(rx_valid), .rx_kind(rx_kind), .rx_byte(rx_byte),
        .rx_parity_err(rx_parity_err), .fct_rcvd(fct_rcvd)
    );

    lc_credit #(.GRANT(CREDIT_PER_FCT), .CREDIT_MAX(CREDIT_MAX)) u_credit (
        .clk(clk), .rst_n(rst_n),
        .grant(fct_rcvd), .take(take), .has_credit(has_credit)
    );

    lc_fct_req #(.GRANT(CREDIT_PER_FCT), .PEND_MAX(FCT_PEND_MAX)) u_fct (
        .clk(clk), .rst_n(rst_n),
        .slot_free(rx_slot_free), .sent(fct_sent), .pending(fct_pending)
    );
endmodule

// File: tb/sim_link_char_codec.sv
module sim_link_char_codec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_valid = 1'b0;
    logic [1:0] tx_kind = 2'd0;
    logic [7:0] tx_byte = 8'd0;
    logic       tx_ready;
    logic       tx_bit;
    logic       rx_bit = 1'b0;
    logic       rx_bit_en = 1'b0;
    logic       rx_slot_free = 1'b0;
    logic       rx_valid;
    logic [1:0] rx_kind;
    logic [7:0] rx_byte;
    logic       rx_parity_err;

    always #2 clk = ~clk;

    link_char_codec u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_kind(tx_kind), .tx_byte(tx_byte),
        .tx_ready(tx_ready), .tx_bit(tx_bit),
        .rx_bit(rx_bit), .rx_bit_en(rx_bit_en), .rx_slot_free(rx_slot_free),
        .rx_valid(rx_valid), .rx_kind(rx_kind), .rx_byte(rx_byte),
        .rx_parity_err(rx_parity_err)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Offered item sequence: kind in [9:8], byte in [7:0].
    function automatic logic [9:0] item(input int i);
        logic [1:0] k;
        k = (i % 9 == 8) ? 2'd1 : ((i % 13 == 12) ? 2'd2 : 2'd0);
        return {k, 8'((i * 29 + 3) & 255)};
    endfunction

    // ---------------- transmit line decoder ----------------
    int tx_items = 0, tx_fct_n = 0, tx_null_n = 0, tx_par_err_n = 0;
    bit first_bits [8];
    int first_n = 0;

    task automatic tx_decoder();
        int  d_pos = 0;
        int  d_len = 10;
        bit  d_par = 0, d_flag = 0, d_prev = 0, d_esc = 0;
        bit [7:0] d_acc = 0;
        logic [9:0] e;
        forever begin
            bit b;
            b = tx_bit;
            if (first_n < 8) begin
                first_bits[first_n] = b;
                first_n++;
            end
            if (d_pos == 0) begin
                d_par = b;
            end else if (d_pos == 1) begin
                d_flag = b;
                if ((d_par ^ d_prev ^ b) != 1'b1) tx_par_err_n++;
                d_acc = 0;
                d_len = b ? 4 : 10;
            end else begin
                d_acc[d_pos-2] = b;
            end
            d_pos++;
            if (d_pos >= 4 && d_pos == d_len) begin
                d_pos  = 0;
                d_prev = ^d_acc;
                if (d_flag && d_acc[1:0] == 2'd3) begin
                    d_esc = 1;
                end else if (d_flag && d_acc[1:0] == 2'd0) begin
                    if (d_esc) tx_null_n++; else tx_fct_n++;
                    d_esc = 0;
                end else begin
                    d_esc = 0;
                    e = item(tx_items);
                    if (d_flag) begin
                        chk(e[9:8] == d_acc[1:0], "R2 tx end kind", int'(d_acc[1:0]), int'(e[9:8]));
                    end else begin
                        chk(e[9:8] == 2'd0 && e[7:0] == d_acc, "R2 tx data byte", int'(d_acc), int'(e[7:0]));
                    end
                    tx_items++;
                end
            end
            @(negedge clk);
        end
    endtask

    // ---------------- transmit item feeder ----------------
    int src_i = 0, pops = 0;
    bit pop_pend = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            bit t;
            logic [9:0] e;
            t = tx_valid && tx_ready;
            if (pop_pend) begin
                src_i++;
                pops++;
            end
            pop_pend = t;
            e = item(src_i);
            tx_kind = e[9:8];
            tx_byte = e[7:0];
        end
    end

    // ---------------- receive side ----------------
    bit enc_prev = 0;
    int exp_q[$];
    int rx_perr_n = 0, rx_out_n = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_parity_err) rx_perr_n++;
            if (rx_valid) begin
                int e;
                rx_out_n++;
                if (exp_q.size() == 0) begin
                    chk(0, "R7 unexpected rx item", int'({rx_kind, rx_byte}), -1);
                end else begin
                    e = exp_q.pop_front();
                    chk(int'({rx_kind, rx_byte}) == e, "R7 rx item", int'({rx_kind, rx_byte}), e);
                end
            end
        end
    end

    task automatic send_bit(input bit b);
        @(negedge clk);
        rx_bit    = b;
        rx_bit_en = 1'b1;
    endtask

    task automatic send_char(input bit ctrl, input logic [7:0] val, input bit flip);
        int n;
        n = ctrl ? 2 : 8;
        if (!flip && !ctrl) exp_q.push_back(int'({2'd0, val}));
        if (!flip && ctrl && (val[1:0] == 2'd1 || val[1:0] == 2'd2))
            exp_q.push_back(int'({val[1:0], 8'd0}));
        send_bit(~(enc_prev ^ ctrl) ^ flip);
        send_bit(ctrl);
        for (int i = 0; i < n; i++) send_bit(val[i]);
        enc_prev = ctrl ? ^val[1:0] : ^val;
        @(negedge clk);
        rx_bit_en = 1'b0;
    endtask

    task automatic pulse_slots(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) rx_slot_free = 1'b1;
            @(negedge clk) rx_slot_free = 1'b0;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int snap, f0, waited;
        logic [7:0] exp_bits;
        tx_valid = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork tx_decoder(); join_none

        // R1: idle pair right after reset
        repeat (20) @(negedge clk);
        exp_bits = 8'b0010_1110; // line order 0,1,1,1,0,1,0,0 read from bit 0
        for (int i = 0; i < 8; i++)
            chk(first_bits[i] == exp_bits[i], "R1 reset line bit", int'(first_bits[i]), int'(exp_bits[i]));

        // R4 / R5: no credit, item offered -> only idle pairs
        repeat (300) @(negedge clk);
        chk(tx_items == 0, "R5 no send without credit", tx_items, 0);
        chk(tx_null_n > 20, "R4 idle pairs while blocked", tx_null_n, 21);
        chk(tx_ready === 1'b0 && pops == 0, "R11 no take without credit", pops, 0);

        // R8: idle pairs received grant nothing and forward nothing
        for (int i = 0; i < 4; i++) begin
            send_char(1, 8'd3, 0);
            send_char(1, 8'd0, 0);
        end
        repeat (200) @(negedge clk);
        chk(tx_items == 0, "R8 received idle grants no credit", tx_items, 0);
        chk(rx_out_n == 0, "R8 flow token not forwarded", rx_out_n, 0);

        // R5: one token grants exactly eight
        send_char(1, 8'd0, 0);
        repeat (400) @(negedge clk);
        chk(tx_items == 8, "R5 one token grants 8", tx_items, 8);
        send_char(1, 8'd0, 0);
        send_char(1, 8'd0, 0);
        repeat (500) @(negedge clk);
        chk(tx_items == 24, "R5 two tokens grant 16 more", tx_items, 24);
        chk(rx_out_n == 0, "R8 tokens not forwarded", rx_out_n, 0);

        // R10: seven freed slots send no token, the eighth sends one
        f0 = tx_fct_n;
        pulse_slots(7);
        repeat (100) @(negedge clk);
        chk(tx_fct_n == f0, "R10 seven slots no token", tx_fct_n, f0);
        pulse_slots(1);
        repeat (100) @(negedge clk);
        chk(tx_fct_n == f0 + 1, "R10 eighth slot sends token", tx_fct_n, f0 + 1);

        // R6: token queued while data flows goes out ahead of data
        for (int i = 0; i < 5; i++) send_char(1, 8'd0, 0);
        repeat (100) @(negedge clk);
        f0 = tx_fct_n;
        pulse_slots(8);
        snap = tx_items;
        waited = 0;
        while (tx_fct_n == f0 && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        chk(tx_fct_n == f0 + 1, "R6 token sent during data", tx_fct_n, f0 + 1);
        chk(tx_items - snap <= 2, "R6 token ahead of data", tx_items - snap, 2);
        repeat (700) @(negedge clk);
        chk(tx_items == 64, "R5 five tokens grant 40 more", tx_items, 64);

        // R7: every data byte, then both end markers
        for (int v = 0; v < 256; v++) send_char(0, 8'(v), 0);
        send_char(1, 8'd1, 0);
        send_char(1, 8'd2, 0);
        repeat (30) @(negedge clk);
        chk(rx_out_n == 258, "R7 all items forwarded", rx_out_n, 258);

        // R9: a parity failure is flagged and the character dropped
        send_char(0, 8'h5A, 1);
        repeat (20) @(negedge clk);
        chk(rx_perr_n == 1, "R9 parity error flagged", rx_perr_n, 1);
        chk(rx_out_n == 258, "R9 bad char dropped", rx_out_n, 258);
        send_char(0, 8'hC3, 0);
        send_char(1, 8'd0, 1);
        repeat (200) @(negedge clk);
        chk(rx_out_n == 259, "R9 next good char forwarded", rx_out_n, 259);
        chk(rx_perr_n == 2, "R9 bad token flagged", rx_perr_n, 2);
        chk(tx_items == 64, "R9 bad token grants no credit", tx_items, 64);

        // R3 / R11: parity of every sent character, one send per take
        chk(tx_par_err_n == 0, "R3 tx parity", tx_par_err_n, 0);
        chk(pops == tx_items, "R11 takes match sent items", pops, tx_items);
        chk(exp_q.size() == 0, "R7 nothing left pending", exp_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule